// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from a set of device slots onto four shared interrupt lines. Each slot has four request pins. Every pin is routed to one shared line by a swizzle that depends on the slot number, so that pin 0 of neighbouring slots lands on different lines and the load is spread evenly.

The block does not build a plain OR tree. It keeps one stored copy of every pin level and, for each shared line, a reference count of the stored pins that are high and route to that line. A pin counts as pending when its input level differs from its stored copy. One pending pin is committed per clock. A round-robin pointer picks the pin, so a burst of simultaneous changes is drained fully and no pin can be starved. When a pin is committed, its stored level is updated and the counter of its line moves up or down by one. A line is driven high while its counter is non-zero.

The block is placed between the device request wires and an interrupt controller that samples the four lines.

Top module: `irq_line_aggregator`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every stored pin level and every counter, so all four lines are low after that edge. Pins that are still high after reset are detected again as new changes.
- R2: Request bit `req[s*4+p]` is pin p of slot s. It drives shared line `irq_line[(s+p) mod 4]`.
- R3: Once all changes are committed, `irq_line[l]` is high exactly when at least one request pin routed to line l is high. A second pin on the same line keeps the line high when the first pin drops.
- R4: When exactly one pin changes and nothing else is pending, the output reflects the change after the next rising clock edge.
- R5: At most one stored pin level changes per clock edge. N changes presented together are all reflected after N edges.
- R6: A pin whose input level equals its stored level causes no action, so the lines stay stable while nothing is pending.
- R7: Pending pins are served in round-robin order from the pin after the one last served. A pin that toggles every cycle cannot starve another pending pin.
- R8: No line counter ever exceeds the number of slots, and counters never wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_SLOTS*4 | Request levels; bit s*4+p is pin p of slot s |
| irq_line | output | 4 | Aggregated shared interrupt lines |

## Verification
A stored level or counter that is wrong shows at the ports as a line that stays high after every pin routed to it has dropped, or as a line that never rises. Because the lines come straight from the counters, such a fault appears one edge after the bad commit and then persists. A broken arbiter shows as a line that stays low past the drain window, which is N edges for N pending pins, or past two edges while a neighbouring pin toggles. Routing faults show in the single-pin sweep as the wrong line rising one edge after the pin rises.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int PINS_PER_SLOT = 4;
    localparam int NUM_LINES     = 4;

    typedef logic [1:0] line_t;

    // Slot-dependent swizzle: shared line = (slot + pin) mod 4
    function automatic line_t swizzle(input int unsigned slot, input int unsigned pin);
        int unsigned sum;
        sum = (slot + pin) % NUM_LINES;
        return line_t'(sum);
    endfunction

endpackage

// File: rtl/irqagg_scan.sv
module irqagg_scan #(
    parameter int NUM_PINS = 128,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] req,
    output logic [NUM_PINS-1:0] lvl_q,
    output logic                pend_any,
    output logic                fire,
    output logic [IDX_W-1:0]    fire_idx,
    output logic                fire_up
);

    logic [NUM_PINS-1:0] pend;
    logic [IDX_W-1:0]    ptr_q;
    logic [IDX_W-1:0]    pick_idx;
    logic                found;

    // Round-robin search starting at the pointer, wrapping once
    always_comb begin
        int j;
        pend     = req ^ lvl_q;
        pend_any = |pend;
        found    = 1'b0;
        pick_idx = '0;
        for (int k = 0; k < NUM_PINS; k++) begin
            j = int'(ptr_q) + k;
            if (j >= NUM_PINS) begin
                j = j - NUM_PINS;
            end
            if (!found && pend[j]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(j);
            end
        end
    end

    assign fire     = pend_any && found;
    assign fire_idx = pick_idx;
    assign fire_up  = req[pick_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            ptr_q <= '0;
        end else if (fire) begin
            lvl_q[pick_idx] <= req[pick_idx];
            ptr_q <= (pick_idx == IDX_W'(NUM_PINS - 1)) ? '0 : pick_idx + 1'b1;
        end
    end

endmodule

// File: rtl/irqagg_route.sv
module irqagg_route #(
    parameter int NUM_PINS = 128,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic [IDX_W-1:0]      pin_idx,
    output irqagg_pkg::line_t     line
);

    always_comb begin
        int unsigned slot;
        int unsigned pin;
        slot = int'(pin_idx) / irqagg_pkg::PINS_PER_SLOT;
        pin  = int'(pin_idx) % irqagg_pkg::PINS_PER_SLOT;
        line = irqagg_pkg::swizzle(slot, pin);
    end

endmodule

// File: rtl/irqagg_count.sv
module irqagg_count #(
    parameter int NUM_LINES = 4,
    parameter int CNT_W     = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd,
    input  irqagg_pkg::line_t          upd_line,
    input  logic                       upd_up,
    output logic [NUM_LINES*CNT_W-1:0] cnt_flat,
    output logic [NUM_LINES-1:0]       line_out
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (upd && (int'(upd_line) == g)) begin
                if (upd_up) begin
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end

        assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q;
        assign line_out[g] = (cnt_q != '0);
    end

endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator #(
    parameter int NUM_SLOTS = 32
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic [NUM_SLOTS*irqagg_pkg::PINS_PER_SLOT-1:0] req,
    output logic [irqagg_pkg::NUM_LINES-1:0]           irq_line
);

    localparam int NUM_PINS = NUM_SLOTS * irqagg_pkg::PINS_PER_SLOT;
    localparam int IDX_W    = $clog2(NUM_PINS);
    localparam int CNT_W    = $clog2(NUM_SLOTS + 1);
    localparam int LINES    = irqagg_pkg::NUM_LINES;

    logic [NUM_PINS-1:0]    lvl_q;
    logic                   pend_any;
    logic                   fire;
    logic [IDX_W-1:0]       fire_idx;
    logic                   fire_up;
    irqagg_pkg::line_t      fire_line;
    logic [LINES*CNT_W-1:0] cnt_flat;

    irqagg_scan #(.NUM_PINS(NUM_PINS)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .lvl_q    (lvl_q),
        .pend_any (pend_any),
        .fire     (fire),
        .fire_idx (fire_idx),
        .fire_up  (fire_up)
    );

    irqagg_route #(.NUM_PINS(NUM_PINS)) u_route (
        .pin_idx (fire_idx),
        .line    (fire_line)
    );

    irqagg_count #(.NUM_LINES(LINES), .CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .upd      (fire),
        .upd_line (fire_line),
        .upd_up   (fire_up),
        .cnt_flat (cnt_flat),
        .line_out (irq_line)
    );

endmodule

// File: rtl/irq_line_aggregator_chk.sv
module irq_line_aggregator_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int CNT_W     = 6,
    localparam int NUM_PINS = NUM_SLOTS * 4
) (
    input logic                clk,
    input logic                rst,
    input logic [3:0]          irq_line,
    input logic [NUM_PINS-1:0] lvl_q,
    input logic                pend_any,
    input logic [4*CNT_W-1:0]  cnt_flat
);

    function automatic logic [NUM_PINS-1:0] line_mask(input int l);
        logic [NUM_PINS-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (((i / 4) + (i % 4)) % 4 == l) begin
                m[i] = 1'b1;
            end
        end
        return m;
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (irq_line == 4'b0000)); // R1

    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        $countones(lvl_q ^ $past(lvl_q)) <= 1); // R5

    AST_PENDING_SERVED: assert property (@(posedge clk) disable iff (rst)
        pend_any |=> (lvl_q != $past(lvl_q))); // R4

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (rst)
        !pend_any |=> $stable(irq_line)); // R6

    for (genvar l = 0; l < 4; l++) begin : g_chk
        localparam logic [NUM_PINS-1:0] MASK = line_mask(l);

        AST_LINE_MATCH: assert property (@(posedge clk) disable iff (rst)
            irq_line[l] == |(lvl_q & MASK)); // R3

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            int'(cnt_flat[l*CNT_W +: CNT_W]) <= NUM_SLOTS); // R8
    end

endmodule

bind irq_line_aggregator irq_line_aggregator_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_line (irq_line),
    .lvl_q    (lvl_q),
    .pend_any (pend_any),
    .cnt_flat (cnt_flat)
);

// File: tb/irq_line_aggregator_test.sv
`timescale 1ns/1ps
module irq_line_aggregator_test;

    localparam int SLOTS = 8;
    localparam int NP    = SLOTS * 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] req = '0;
    logic [3:0]    irq_line;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_line_aggregator #(.NUM_SLOTS(SLOTS)) uut (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .irq_line (irq_line)
    );

    function automatic logic [3:0] model_lines(input logic [NP-1:0] v);
        logic [3:0] r;
        r = 4'b0000;
        for (int i = 0; i < NP; i++) begin
            if (v[i]) r[((i / 4) + (i % 4)) % 4] = 1'b1;
        end
        return r;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired actual=%b expected=drained", irq_line);
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        logic [3:0]  exp;

        tick(3);
        check(irq_line == 4'b0000, "R1 reset state", irq_line, 4'b0000);
        rst = 1'b0;
        tick(2);
        check(irq_line == 4'b0000, "R1 idle after reset", irq_line, 4'b0000);

        // R2 / R4: single-pin sweep, one edge latency
        for (int i = 0; i < NP; i++) begin
            req = '0;
            req[i] = 1'b1;
            tick(1);
            exp = 4'b0001 << (((i / 4) + (i % 4)) % 4);
            check(irq_line == exp, $sformatf("R2 R4 pin %0d rise", i), irq_line, exp);
            req[i] = 1'b0;
            tick(1);
            check(irq_line == 4'b0000, $sformatf("R4 pin %0d fall", i), irq_line, 4'b0000);
        end

        // R6: rewriting identical levels changes nothing
        req[6] = 1'b1;              // slot1 pin2 -> line3
        tick(1);
        for (int k = 0; k < 6; k++) begin
            req[6] = 1'b1;
            tick(1);
            check(irq_line == 4'b1000, "R6 unchanged level", irq_line, 4'b1000);
        end
        req = '0;
        tick(1);

        // R3: two pins sharing line1 (slot0 pin1, slot1 pin0)
        req[1] = 1'b1;
        req[4] = 1'b1;
        tick(2);
        check(irq_line == 4'b0010, "R3 shared both high", irq_line, 4'b0010);
        req[1] = 1'b0;
        tick(1);
        check(irq_line == 4'b0010, "R3 shared one remains", irq_line, 4'b0010);
        req[4] = 1'b0;
        tick(1);
        check(irq_line == 4'b0000, "R3 shared both low", irq_line, 4'b0000);

        // R5: burst of all pins, one commit per edge
        req = '1;
        for (int k = 1; k <= 4; k++) begin
            tick(1);
            check($countones(irq_line) <= k, $sformatf("R5 burst after %0d edges", k), irq_line, 4'b1111);
        end
        tick(NP - 4);
        check(irq_line == 4'b1111, "R5 burst drained", irq_line, 4'b1111);
        req = '0;
        req[5] = 1'b1;              // slot1 pin1 -> line2
        tick(NP - 1);
        check(irq_line == 4'b0100, "R5 R3 burst release", irq_line, 4'b0100);
        req = '0;
        tick(1);
        check(irq_line == 4'b0000, "R3 all clear", irq_line, 4'b0000);

        // R7: pin 0 toggles every cycle, pin 1 must still be served
        req[1] = 1'b1;
        for (int k = 0; k < 8; k++) begin
            req[0] = ~req[0];
            tick(1);
        end
        check(irq_line[1] == 1'b1, "R7 no starvation", irq_line, 4'b0010);
        req = '0;
        tick(NP);
        check(irq_line == 4'b0000, "R7 settle", irq_line, 4'b0000);

        // R3: pseudo-random patterns, compare after full drain
        lfsr = 32'hACE1_2468;
        for (int it = 0; it < 40; it++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            req = lfsr[NP-1:0] & {NP{it[0]}} | (lfsr[NP-1:0] & lfsr[NP-1:0] >> 3);
            tick(NP);
            exp = model_lines(req);
            check(irq_line == exp, $sformatf("R3 pattern %0d", it), irq_line, exp);
        end

        // R1: reset mid-operation, then re-detection of held pins
        req = '1;
        tick(NP);
        check(irq_line == 4'b1111, "R1 before reset", irq_line, 4'b1111);
        rst = 1'b1;
        tick(1);
        check(irq_line == 4'b0000, "R1 reset clears lines", irq_line, 4'b0000);
        tick(1);
        rst = 1'b0;
        tick(NP);
        check(irq_line == 4'b1111, "R1 held pins re-detected", irq_line, 4'b1111);
        req = '0;
        tick(NP);
        check(irq_line == 4'b0000, "R8 counters return to zero", irq_line, 4'b0000);

        finish_run();
    end

endmodule